// File: doc/BRIEF.md
# PHY Management Serial Master

This block lets software talk to external Ethernet PHYs over the two-wire management bus (a clock, MDC, and a bidirectional data line, MDIO). Software writes one 32-bit word into a frame register. That word already holds the whole management frame: start code, operation, PHY address, register address, turnaround and 16 data bits. The block first sends a preamble of ones and then shifts the frame out most significant bit first. For a read operation it releases the data line, collects the 16 bits the PHY returns, and places them in the low half of the same frame register.

The MDC rate comes from a speed register. A 6-bit speed field N is stored one bit up from the bottom of that register. MDC then runs at the system clock divided by 2×N. Software normally programs N as the system clock divided by 5 MHz, rounded up, so that MDC stays at or below 2.5 MHz. When a frame finishes, a completion flag is raised in an event register. Software clears that flag by writing a one to it. A busy indication in the same register shows that a frame is in flight. When nothing answers a read, the pulled-up line makes the result all ones.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the frame, speed and event registers read as zero, MDC is low and MDIO is released (output enable low).
- R2: A write to the frame register (address 0) while idle and with a nonzero speed field starts a frame. Event register (address 2) bit 0 reads 1 from the next cycle until the frame ends.
- R3: The speed field is bits 6:1 of the speed register (address 1) and reads back in place. With speed field N, MDC is high for N clock cycles and low for N cycles, giving a period of 2×N cycles.
- R4: Each frame sends 32 ones followed by frame bits 31 down to 0, one bit per MDC period. MDIO changes only together with an MDC falling edge and is stable while MDC is high. A frame spans exactly 64 MDC rising edges.
- R5: A frame whose bits 29:28 equal 2'b10 is a read. The master releases MDIO from the slot of frame bit 17 until the end of the frame. It samples 16 bits on the MDC rising edges that follow the turnaround, MSB first, and writes them into frame register bits 15:0; bits 31:16 keep their value.
- R6: A read to an address where no PHY answers leaves 0xFFFF in frame register bits 15:0.
- R7: Any other operation code drives all 64 bits. The frame register keeps the written word after completion.
- R8: Completion sets event register bit 23. Writing the event register with bit 23 set clears it, and writing it with bit 23 clear leaves it set.
- R9: A write to the frame register while busy is ignored. The register keeps the word of the running frame, and that frame runs to its end unchanged.
- R10: With a speed field of zero, a write to the frame register stores the word, but no MDC edge appears and busy stays 0.
- R11: Between frames MDC is held low and MDIO is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 frame, 1 speed, 2 event |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for the selected address |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data value driven on MDIO |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | Resolved MDIO line value |

## Verification
The checks assume that software does not rewrite the speed register while a frame is in flight. They also assume that `mdio_i` carries the resolved line: the master's own value while it drives, the PHY's value or the pull-up while it does not. The bench changes speed only between frames. Its PHY model drives MDIO only after MDC falling edges during the turnaround and data slots of a read addressed to it, and otherwise leaves the line pulled high. The bench waits for the completion flag before it issues the next frame. The only exception is the deliberate write while busy used to test R9.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   typedef enum logic [1:0] {
      SEL_FRAME = 2'd0,
      SEL_SPEED = 2'd1,
      SEL_EVENT = 2'd2,
      SEL_NONE  = 2'd3
   } reg_sel_e;

   localparam int EVT_DONE_BIT = 23;
   localparam int EVT_BUSY_BIT = 0;
   localparam logic [1:0] OPC_READ = 2'b10;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
   parameter int SPD_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SPD_W-1:0] half,
   output logic             mdc,
   output logic             rise,
   output logic             fall
);
   logic [SPD_W-1:0] cnt_q;
   logic             mdc_q;
   logic             term;

   assign term = (cnt_q == half - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (term) begin
         cnt_q <= '0;
         mdc_q <= ~mdc_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign mdc  = mdc_q;
   assign rise = run & term & ~mdc_q;
   assign fall = run & term & mdc_q;
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter #(
   parameter int PRE_LEN    = 32,
   parameter int FRAME_W    = 32,
   parameter int DATA_W     = 16,
   parameter bit IDLE_DRIVE = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] frame,
   input  logic               rise,
   input  logic               fall,
   input  logic               mdio_i,
   output logic               busy,
   output logic               done,
   output logic               rd_op,
   output logic [DATA_W-1:0]  rx_data,
   output logic               mdio_o,
   output logic               mdio_oe
);
   import mdio_pkg::*;

   localparam int TOTAL    = PRE_LEN + FRAME_W;
   localparam int SLOT_W   = $clog2(TOTAL);
   localparam int FIDX_W   = $clog2(FRAME_W);
   localparam int LAST     = TOTAL - 1;
   localparam int REL_SLOT = TOTAL - DATA_W - 2;
   localparam int CAP_SLOT = TOTAL - DATA_W;

   generate
      if (FRAME_W < DATA_W + 16) begin : g_bad_frame
         $error("frame word too narrow for header plus data");
      end
      if (PRE_LEN < 1) begin : g_bad_pre
         $error("preamble length must be positive");
      end
   endgenerate

   logic              busy_q, done_q;
   logic [SLOT_W-1:0] slot_q;
   logic [DATA_W-1:0] rx_q;
   logic [SLOT_W-1:0] bit_pos;
   logic              drive_bit, released;

   assign rd_op = (frame[FRAME_W-3:FRAME_W-4] == OPC_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         slot_q <= '0;
         rx_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               busy_q <= 1'b1;
               slot_q <= '0;
            end
         end else begin
            if (rise && rd_op && slot_q >= SLOT_W'(CAP_SLOT))
               rx_q <= {rx_q[DATA_W-2:0], mdio_i};
            if (fall) begin
               if (slot_q == SLOT_W'(LAST)) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
                  slot_q <= '0;
               end else begin
                  slot_q <= slot_q + 1'b1;
               end
            end
         end
      end
   end

   assign bit_pos   = SLOT_W'(LAST) - slot_q;
   assign drive_bit = (slot_q < SLOT_W'(PRE_LEN)) ? 1'b1 : frame[bit_pos[FIDX_W-1:0]];
   assign released  = rd_op && (slot_q >= SLOT_W'(REL_SLOT));

   generate
      if (IDLE_DRIVE) begin : g_idle_drive
         assign mdio_oe = ~busy_q | ~released;
      end else begin : g_idle_release
         assign mdio_oe = busy_q & ~released;
      end
   endgenerate

   assign mdio_o  = busy_q ? drive_bit : 1'b1;
   assign busy    = busy_q;
   assign done    = done_q;
   assign rx_data = rx_q;
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs #(
   parameter int FRAME_W = 32,
   parameter int DATA_W  = 16,
   parameter int SPD_W   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_we,
   input  logic [1:0]         bus_addr,
   input  logic [FRAME_W-1:0] bus_wdata,
   output logic [FRAME_W-1:0] bus_rdata,
   input  logic               busy,
   input  logic               done,
   input  logic               rd_op,
   input  logic [DATA_W-1:0]  rx_data,
   output logic [FRAME_W-1:0] frame,
   output logic [SPD_W-1:0]   half,
   output logic               start
);
   import mdio_pkg::*;

   generate
      if (FRAME_W <= EVT_DONE_BIT || FRAME_W < SPD_W + 1) begin : g_bad_bus
         $error("register width too small for field layout");
      end
   endgenerate

   logic [FRAME_W-1:0] frame_q;
   logic [SPD_W-1:0]   spd_q;
   logic               evt_q;
   logic               wr_frame, wr_speed, wr_event;
   reg_sel_e           sel;

   assign sel      = reg_sel_e'(bus_addr);
   assign wr_frame = bus_we && sel == SEL_FRAME && !busy;
   assign wr_speed = bus_we && sel == SEL_SPEED;
   assign wr_event = bus_we && sel == SEL_EVENT;
   assign start    = wr_frame && (spd_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '0;
         spd_q   <= '0;
         evt_q   <= 1'b0;
      end else begin
         if (wr_frame)
            frame_q <= bus_wdata;
         else if (done && rd_op)
            frame_q[DATA_W-1:0] <= rx_data;
         if (wr_speed)
            spd_q <= bus_wdata[SPD_W:1];
         if (done)
            evt_q <= 1'b1;
         else if (wr_event && bus_wdata[EVT_DONE_BIT])
            evt_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (sel)
         SEL_FRAME: bus_rdata = frame_q;
         SEL_SPEED: bus_rdata[SPD_W:1] = spd_q;
         SEL_EVENT: begin
            bus_rdata[EVT_DONE_BIT] = evt_q;
            bus_rdata[EVT_BUSY_BIT] = busy;
         end
         default:   bus_rdata = '0;
      endcase
   end

   assign frame = frame_q;
   assign half  = spd_q;
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
   parameter int PRE_LEN    = 32,
   parameter int FRAME_W    = 32,
   parameter int DATA_W     = 16,
   parameter int SPD_W      = 6,
   parameter bit IDLE_DRIVE = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_we,
   input  logic [1:0]         bus_addr,
   input  logic [FRAME_W-1:0] bus_wdata,
   output logic [FRAME_W-1:0] bus_rdata,
   output logic               mdc,
   output logic               mdio_o,
   output logic               mdio_oe,
   input  logic               mdio_i
);
   logic               w_busy, w_done, w_rd_op, w_start, w_rise, w_fall;
   logic [DATA_W-1:0]  w_rx;
   logic [FRAME_W-1:0] w_frame;
   logic [SPD_W-1:0]   w_half;

   mdio_regs #(.FRAME_W(FRAME_W), .DATA_W(DATA_W), .SPD_W(SPD_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(w_busy),
      .done(w_done), .rd_op(w_rd_op), .rx_data(w_rx), .frame(w_frame),
      .half(w_half), .start(w_start)
   );

   mdio_clkdiv #(.SPD_W(SPD_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(w_busy), .half(w_half),
      .mdc(mdc), .rise(w_rise), .fall(w_fall)
   );

   mdio_shifter #(.PRE_LEN(PRE_LEN), .FRAME_W(FRAME_W), .DATA_W(DATA_W),
                  .IDLE_DRIVE(IDLE_DRIVE)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(w_start), .frame(w_frame),
      .rise(w_rise), .fall(w_fall), .mdio_i(mdio_i), .busy(w_busy),
      .done(w_done), .rd_op(w_rd_op), .rx_data(w_rx), .mdio_o(mdio_o),
      .mdio_oe(mdio_oe)
   );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk #(
   parameter int SPD_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mdc,
   input logic             mdio_o,
   input logic             busy,
   input logic             done,
   input logic             evt,
   input logic [SPD_W-1:0] spd
);
   p_mdc_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);

   p_no_start_zero_spd_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (spd == '0 && !busy) |=> !busy);

   p_mdio_hold_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mdc && $past(mdc)) |-> $stable(mdio_o));

   p_done_flags_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> evt);

   p_done_ends_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk #(.SPD_W(SPD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .busy(w_busy),
   .done(w_done), .evt(u_regs.evt_q), .spd(w_half)
);

// File: tb/mdio_mgmt_master_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_master_bench;
   localparam int PHY_ADDR = 5;
   localparam int NVEC = 6;
   // entry: {speed field[5:0], frame word[31:0]}
   localparam logic [37:0] VEC [NVEC] = '{
      {6'd2, 32'h628A0000},  // read phy 5 reg 2
      {6'd1, 32'h62FE0000},  // read phy 5 reg 31
      {6'd3, 32'h63860000},  // read phy 7 reg 1 (absent)
      {6'd2, 32'h528EBEEF},  // write phy 5 reg 3
      {6'd5, 32'h50020001},  // write phy 0 reg 0
      {6'd1, 32'h62820000}   // read phy 5 reg 0
   };

   logic clk = 0, rst_n = 0, bus_we = 0;
   logic [1:0]  bus_addr = 0;
   logic [31:0] bus_wdata = 0, bus_rdata;
   logic mdc, mdio_o, mdio_oe, mdio_i;
   logic drv_en = 0, drv_bit = 1;
   int total = 0, bad = 0;

   always #4 clk = ~clk;

   assign mdio_i = mdio_oe ? mdio_o : (drv_en ? drv_bit : 1'b1);

   mdio_mgmt_master u_mdio_mgmt_master (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // PHY model
   int edge_n = 0, fall_n = 0;
   logic pre_bad = 0, rel_bad = 0, hit = 0, rd_seen = 0;
   logic [31:0] cap = 0;
   logic [15:0] phy_val = 0;
   time t_r1 = 0, t_r2 = 0, t_f1 = 0;

   always @(posedge mdc) begin
      edge_n++;
      if (edge_n == 1) t_r1 = $time;
      if (edge_n == 2) t_r2 = $time;
      if (edge_n <= 32) begin
         if (!mdio_i) pre_bad = 1;
      end else cap = {cap[30:0], mdio_i};
      if (edge_n == 46) begin
         rd_seen = (cap[11:10] == 2'b10);
         hit = rd_seen && (cap[9:5] == 5'(PHY_ADDR));
         phy_val = 16'hA5C3 ^ {11'd0, cap[4:0]};
      end
      if (edge_n >= 47 && rd_seen && mdio_oe) rel_bad = 1;
   end

   always @(negedge mdc) begin
      fall_n++;
      if (fall_n == 1) t_f1 = $time;
      if (hit) begin
         if (fall_n == 47) begin drv_en = 1; drv_bit = 0; end
         else if (fall_n >= 48 && fall_n <= 63) drv_bit = phy_val[63-fall_n];
         else if (fall_n >= 64) drv_en = 0;
      end
   end

   task automatic phy_clear();
      edge_n = 0; fall_n = 0; pre_bad = 0; rel_bad = 0;
      hit = 0; rd_seen = 0; cap = 0; drv_en = 0;
   endtask

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_done(output bit ok);
      logic [31:0] e;
      ok = 0;
      for (int i = 0; i < 20000; i++) begin
         rd(2'd2, e);
         if (e[23]) begin ok = 1; break; end
      end
   endtask

   function automatic logic [15:0] expect_low(input logic [31:0] f);
      if (f[29:28] != 2'b10) return f[15:0];
      if (f[27:23] == 5'(PHY_ADDR)) return 16'hA5C3 ^ {11'd0, f[22:18]};
      return 16'hFFFF;
   endfunction

   task automatic run_vec(input logic [5:0] spd, input logic [31:0] f);
      logic [31:0] d;
      bit ok;
      wr(2'd1, {25'd0, spd, 1'b0});
      rd(2'd1, d);
      chk(d == {25'd0, spd, 1'b0}, "R3 speed readback", d, {25'd0, spd, 1'b0});
      phy_clear();
      wr(2'd0, f);
      rd(2'd2, d);
      chk(d[0] == 1'b1, "R2 busy", d, 32'h1);
      wait_done(ok);
      chk(ok, "R8 done flag", {31'd0, ok}, 32'h1);
      rd(2'd2, d);
      chk(d[0] == 1'b0, "R2 busy cleared", d, 32'h0080_0000);
      rd(2'd0, d);
      chk(d[15:0] == expect_low(f), f[29:28] == 2'b10 ? "R5/R6 read data" : "R7 write keep", {16'd0, d[15:0]}, {16'd0, expect_low(f)});
      chk(d[31:16] == f[31:16], "R5 upper half", {16'd0, d[31:16]}, {16'd0, f[31:16]});
      chk(edge_n == 64, "R4 edge count", edge_n, 64);
      chk(!pre_bad, "R4 preamble", {31'd0, pre_bad}, 0);
      if (f[29:28] == 2'b10) begin
         chk(cap[31:18] == f[31:18], "R4 read header", cap, f);
         chk(!rel_bad, "R5 release", {31'd0, rel_bad}, 0);
      end else begin
         chk(cap == f, "R7 frame bits", cap, f);
      end
      chk((t_r2 - t_r1) == 64'(16 * spd), "R3 period", 32'(t_r2 - t_r1), 32'(16 * spd));
      chk((t_f1 - t_r1) == 64'(8 * spd), "R3 high time", 32'(t_f1 - t_r1), 32'(8 * spd));
      @(negedge clk);
      chk(!mdc && !mdio_oe, "R11 idle", {30'd0, mdc, mdio_oe}, 0);
      wr(2'd2, 32'h0080_0000);
   endtask

   initial begin
      #(8 * 150000);
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      bit ok;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      rd(2'd0, d); chk(d == 0, "R1 frame reset", d, 0);
      rd(2'd1, d); chk(d == 0, "R1 speed reset", d, 0);
      rd(2'd2, d); chk(d == 0, "R1 event reset", d, 0);
      chk(!mdc && !mdio_oe, "R1 pins", {30'd0, mdc, mdio_oe}, 0);

      // R10 speed zero: stored, no start
      phy_clear();
      wr(2'd0, 32'h628A0000);
      repeat (50) @(negedge clk);
      rd(2'd2, d); chk(d == 0, "R10 no busy/event", d, 0);
      chk(edge_n == 0, "R10 no mdc", edge_n, 0);
      rd(2'd0, d); chk(d == 32'h628A0000, "R10 word stored", d, 32'h628A0000);

      // table walk
      for (int i = 0; i < NVEC; i++) run_vec(VEC[i][37:32], VEC[i][31:0]);

      // R9 write while busy ignored
      wr(2'd1, 32'h4);
      phy_clear();
      wr(2'd0, 32'h628A0000);
      repeat (10) @(negedge clk);
      wr(2'd0, 32'h50020000);
      rd(2'd0, d); chk(d == 32'h628A0000, "R9 ignored while busy", d, 32'h628A0000);
      wait_done(ok);
      rd(2'd0, d); chk(d == 32'h628AA5C1, "R9 frame completes", d, 32'h628AA5C1);
      chk(cap[31:18] == 14'h18A2, "R9 header unchanged", {18'd0, cap[31:18]}, 32'h18A2);

      // R8 write-one-to-clear
      wr(2'd2, 32'h0000_0001);
      rd(2'd2, d); chk(d[23], "R8 zero write keeps", d, 32'h0080_0000);
      wr(2'd2, 32'h0080_0000);
      rd(2'd2, d); chk(d == 0, "R8 one write clears", d, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule